// File: doc/BRIEF.md
# Global-History XOR Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A pattern table of 2-bit saturating counters is indexed by the low bits of the branch address XORed with a global outcome history. That history is one shift register fed by the resolved outcomes of every branch in the program, so the same branch address can use a different counter for each recent path that led to it.

The fetch stage presents a branch address on the predict port and gets a direction back in the same cycle. It also gets the history value that formed the index. That snapshot travels down the pipeline with the branch. When the branch resolves, the execute stage returns the address, the real outcome, the snapshot and a misprediction flag on the update port. The block then trains the counter that made the prediction and advances the history. On a misprediction the history is rebuilt from the snapshot.

Top module: `gxor_dir_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken), so every address predicts not taken, and the history reads zero on `pred_hist`.
- R2: `pred_taken` is combinational from `pred_pc` in the same cycle, and is 1 exactly when the selected counter is 2 or 3.
- R3: The predict index is `pred_pc[9:0]` XOR the live 10-bit history.
- R4: A taken update increments the selected counter and saturates at 3.
- R5: A not-taken update decrements the selected counter and saturates at 0.
- R6: On an update that is not a misprediction, the history shifts left by one and the outcome enters at bit 0 (1 = taken).
- R7: An update trains the counter at `upd_pc[9:0]` XOR `upd_hist`, not at the index formed with the live history.
- R8: On an update with `upd_mispred` = 1, the history becomes `{upd_hist[8:0], upd_taken}`.
- R9: When a prediction and an update select the same counter in one cycle, the prediction shows the value the counter had before that update.
- R10: While `upd_valid` is 0, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 10 | History snapshot used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | 10 | Snapshot returned from prediction time |
| upd_mispred | input | 1 | The earlier prediction for this branch was wrong |

## Verification
A corrupted counter stays hidden until a prediction selects it. Even then it only shows up if the counter ends up on the other side of the taken threshold. For this reason the bench reads every one of the 1024 entries through the predict port, steering `pred_pc` against the known history, and it checks the saturation ends with update runs long enough to wrap a counter that does not saturate. A wrong history bit is different. It shows on `pred_hist` in the cycle after the update, and it moves every later index, so it is compared after each update. The long mixed run also puts stale snapshots and mispredictions on the update port, which separates the training index from the live one.

// File: rtl/gp_pkg.sv
package gp_pkg;
    localparam int CTR_W = 2;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_MIN  = '0;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);

    function automatic logic [CTR_W-1:0] ctr_next(input logic [CTR_W-1:0] cur,
                                                  input logic taken);
        logic [CTR_W-1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + CTR_W'(1);
        end else begin
            if (cur != CTR_MIN) nxt = cur - CTR_W'(1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input logic [CTR_W-1:0] cur);
        return cur[CTR_W-1];
    endfunction
endpackage

// File: rtl/gp_index_hash.sv
module gp_index_hash #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] pc_low,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = pc_low ^ hist;
    end
endmodule

// File: rtl/gp_history.sv
module gp_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    input  logic              repair,
    input  logic [HIST_W-1:0] snap,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            if (repair) st_d.bits = {snap[HIST_W-2:0], outcome};
            else        st_d.bits = {st_q.bits[HIST_W-2:0], outcome};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.bits;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !repair) |=> (hist == {$past(hist[HIST_W-2:0]), $past(outcome)})); // R6

    AST_HIST_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && repair) |=> (hist == {$past(snap[HIST_W-2:0]), $past(outcome)})); // R8

    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist)); // R10
endmodule

// File: rtl/gp_pattern_table.sv
module gp_pattern_table
    import gp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][CTR_W-1:0] ctr;
    } tbl_state_t;

    tbl_state_t       st_d, st_q;
    logic [CTR_W-1:0] wr_old_d;

    always_comb begin
        st_d     = st_q;
        wr_old_d = st_q.ctr[wr_idx];
        if (wr_en) st_d.ctr[wr_idx] = ctr_next(wr_old_d, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctr <= {DEPTH{CTR_INIT}};
        else        st_q     <= st_d;
    end

    // read of the registered table: same-cycle writes are not visible
    assign rd_ctr = st_q.ctr[rd_idx];

    AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old_d == CTR_MAX) |=> (st_q.ctr[$past(wr_idx)] == CTR_MAX)); // R4

    AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old_d == CTR_MIN) |=> (st_q.ctr[$past(wr_idx)] == CTR_MIN)); // R5

    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R10
endmodule

// File: rtl/gxor_dir_predictor.sv
module gxor_dir_predictor
    import gp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_hist,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_hist,
    input  logic             upd_mispred
);
    localparam int HIST_W = IDX_W;

    logic [HIST_W-1:0] live_hist;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [CTR_W-1:0]  pred_ctr;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

    gp_index_hash #(.IDX_W(IDX_W)) u_pred_hash (
        .pc_low (pred_pc[IDX_W-1:0]),
        .hist   (live_hist),
        .idx    (pred_idx)
    );

    gp_index_hash #(.IDX_W(IDX_W)) u_upd_hash (
        .pc_low (upd_pc[IDX_W-1:0]),
        .hist   (upd_hist),
        .idx    (upd_idx)
    );

    gp_pattern_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    gp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .repair   (upd_mispred),
        .snap     (upd_hist),
        .hist     (live_hist)
    );

    assign pred_taken = ctr_says_taken(pred_ctr);
    assign pred_hist  = live_hist;

    AST_SNAPSHOT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (pred_hist[0] == $past(upd_taken))); // R6
endmodule

// File: tb/gxor_dir_predictor_bench.sv
module gxor_dir_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pred_pc = '0;
    logic             pred_taken;
    logic [IDX_W-1:0] pred_hist;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic             upd_taken = 1'b0;
    logic [IDX_W-1:0] upd_hist = '0;
    logic             upd_mispred = 1'b0;

    int tests = 0;
    int fails = 0;
    int mt [DEPTH];
    logic [IDX_W-1:0] mh;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    gxor_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_gxor_dir_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist), .upd_mispred(upd_mispred)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // probe the counter at table index idx through the predict port
    task automatic probe_idx(input int idx, input string req);
        pred_pc = {$urandom, 10'b0} | PC_W'(IDX_W'(idx) ^ mh);
        #1;
        check(pred_taken == (mt[idx] >= 2), req, int'(pred_taken), int'(mt[idx] >= 2));
    endtask

    task automatic check_hist(input string req);
        #1;
        check(pred_hist == mh, req, int'(pred_hist), int'(mh));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < DEPTH; i++) probe_idx(i, req);
    endtask

    // one update cycle; optionally watch the same counter on the predict port
    task automatic do_update(input logic [IDX_W-1:0] pc, input logic tk,
                             input logic [IDX_W-1:0] snap, input logic mp,
                             input bit same_idx_check);
        int idx;
        @(negedge clk);
        upd_valid   = 1'b1;
        upd_pc      = {22'h2A5, pc};
        upd_taken   = tk;
        upd_hist    = snap;
        upd_mispred = mp;
        idx = int'(pc ^ snap);
        if (same_idx_check) begin
            pred_pc = PC_W'(IDX_W'(idx) ^ mh);
            #1;
            // R9: same-cycle read sees the value before this write
            check(pred_taken == (mt[idx] >= 2), "R9", int'(pred_taken), int'(mt[idx] >= 2));
        end
        @(posedge clk);
        if (tk) begin if (mt[idx] < 3) mt[idx]++; end
        else    begin if (mt[idx] > 0) mt[idx]--; end
        if (mp) mh = {snap[IDX_W-2:0], tk};
        else    mh = {mh[IDX_W-2:0], tk};
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mt[i] = 1;
        mh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: all entries weakly not taken, history clear
        check_hist("R1");
        sweep("R1");

        // R6: history shifts in outcomes at bit 0
        do_update(10'd5, 1'b1, mh, 1'b0, 1'b0);
        check_hist("R6");
        do_update(10'd9, 1'b0, mh, 1'b0, 1'b0);
        check_hist("R6");
        do_update(10'd9, 1'b1, mh, 1'b0, 1'b0);
        check_hist("R6");

        // R4: many taken updates on one index saturate at 3, one not-taken still predicts taken
        for (int k = 0; k < 6; k++) do_update(10'h0F0, 1'b1, 10'h00F, 1'b0, 1'b0);
        do_update(10'h0F0, 1'b0, 10'h00F, 1'b0, 1'b0);
        probe_idx(10'h0FF, "R4");
        do_update(10'h0F0, 1'b0, 10'h00F, 1'b0, 1'b0);
        probe_idx(10'h0FF, "R4");

        // R5: many not-taken updates saturate at 0, one taken still predicts not taken
        for (int k = 0; k < 6; k++) do_update(10'h155, 1'b0, 10'h3C3, 1'b0, 1'b0);
        do_update(10'h155, 1'b1, 10'h3C3, 1'b0, 1'b0);
        probe_idx(10'h155 ^ 10'h3C3, "R5");
        do_update(10'h155, 1'b1, 10'h3C3, 1'b0, 1'b0);
        probe_idx(10'h155 ^ 10'h3C3, "R5");

        // R8: misprediction rebuilds history from the snapshot
        do_update(10'h001, 1'b1, 10'h2AB, 1'b1, 1'b0);
        check_hist("R8");
        do_update(10'h002, 1'b0, 10'h3FF, 1'b1, 1'b0);
        check_hist("R8");

        // R2 / R3 / R7: whole table after directed training
        sweep("R3");

        // R10: update inputs toggle with valid low
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            upd_pc = $urandom; upd_taken = k[0]; upd_hist = IDX_W'($urandom);
            upd_mispred = k[1];
        end
        @(negedge clk);
        check_hist("R10");
        sweep("R10");

        // long mixed run: stale snapshots, mispredictions, same-index reads
        for (int k = 0; k < 3000; k++) begin
            logic [IDX_W-1:0] pc, snap;
            logic tk, mp;
            rng  = next_rng(rng);
            pc   = rng[9:0];
            tk   = rng[10] | rng[11];
            mp   = (rng[14:12] == 3'd0);
            snap = rng[15] ? mh : rng[25:16];
            do_update(pc, tk, snap, mp, (k % 7) == 0);
            check_hist(mp ? "R8" : "R6");
            probe_idx(int'(pc ^ snap), "R7");
            probe_idx(int'(rng[31:22]), "R2");
        end
        sweep("R7");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule